// File: doc/BRIEF.md
# Calendar Alarm Comparator

This block watches a calendar time supplied in BCD by a separate timekeeping unit and produces a one-cycle alarm event pulse when the time agrees with a programmed alarm setting. A four-bit granularity code chooses how much of the time takes part in the comparison. The coarsest setting compares nothing and fires on every half-second tick. The finest compares month, day, hour, minute and second, and so fires once a year. Comparisons are made only on the rising edge of the half-second tick. A match that holds for several clock cycles therefore produces one event.

Software uses a small byte-wide register port with four addresses: a control byte, a repeat count, and a low and a high window onto six stored alarm fields. A two-bit window pointer in the control byte selects the field pair. Each access to the high window steps the pointer down toward zero. Software can set the pointer to 2 and then write day/month, hour/weekday and second/minute in turn. The repeat count limits the number of alarms. It counts down on every event. When it is already zero, the event either turns the alarm off or, with chime on, reloads the count with all ones.

Top module: `rtc_alarm_match`

## Requirements
- R1: After reset the control byte reads 00h, the repeat count reads 00h and `alarm_evt` is low.
- R2: `alarm_evt` is high for exactly one cycle. It is high in the cycle after a rising edge of `half_tick`, and only when a match exists at that edge. Holding `half_tick` high gives no further events.
- R3: Granularity code (control bits 5:2) selects the compared fields, each on top of the previous code unless stated. 0: none. 1: `tm_half`==0. 2: seconds ones digit (bits 3:0). 3: full seconds byte. 4: minutes ones digit. 5: full minutes. 6: hours. 7: weekday. 8: day of month instead of weekday. 9: month. An alarm on 02/29 at code 9 fires only in years whose calendar reaches that date.
- R4: Codes 10 to 15 never produce an event.
- R5: On an event with a nonzero repeat count, the count decreases by one and the enable stays set.
- R6: On an event with a zero count and chime (control bit 6) clear, the enable (control bit 7) clears itself and the count stays 00h.
- R7: On an event with a zero count and chime set, the count becomes FFh and the enable stays set.
- R8: Address 0 is the control byte {enable, chime, code[3:0], pointer[1:0]}; address 1 is the repeat count. Address 2 (low window) maps pointer 0/1/2 to second/hour/day. Address 3 (high window) maps 0/1/2 to minute/weekday/month.
- R9: Each read or write of address 3 decrements the pointer unless it is 0, where it stays. Accesses to address 2 leave the pointer unchanged.
- R10: With pointer 3, both windows read 00h and writes to them change no stored field.
- R11: With the enable clear, no event is produced whatever the time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| half_tick | input | 1 | Half-second tick; rising edge starts a comparison |
| tm_half | input | 1 | 0 in the first half of a second, 1 in the second half |
| tm_sec | input | 8 | Current seconds, BCD |
| tm_min | input | 8 | Current minutes, BCD |
| tm_hour | input | 8 | Current hours, BCD |
| tm_wday | input | 8 | Current weekday, BCD |
| tm_day | input | 8 | Current day of month, BCD |
| tm_month | input | 8 | Current month, BCD |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register, combinational |
| alarm_evt | output | 1 | Alarm event pulse |

## Verification
The assertions assume three things about the inputs. A register write never falls in the same cycle as the tick edge it is checked against. Read and write strobes target one address per cycle. The time fields are stable while the tick is high. The stimulus meets these assumptions in three ways. Bus accesses and ticks are issued by separate tasks that never overlap. Time values change only while the tick is low. Held ticks of two cycles are mixed in so the edge detection is exercised. Random alarm settings are compared against time values copied from the alarm with random fields disturbed, so that matches and near-misses both occur at every granularity code.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;
   localparam int FIELD_W = 8;
   localparam int PTR_W   = 2;
   localparam int CODE_W  = 4;
   localparam int ADDR_W  = 2;

   localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
   localparam logic [ADDR_W-1:0] ADDR_RPT  = 2'd1;
   localparam logic [ADDR_W-1:0] ADDR_WLO  = 2'd2;
   localparam logic [ADDR_W-1:0] ADDR_WHI  = 2'd3;

   localparam logic [CODE_W-1:0] CODE_LAST = 4'd9;

   typedef struct packed {
      logic [FIELD_W-1:0] month;
      logic [FIELD_W-1:0] day;
      logic [FIELD_W-1:0] wday;
      logic [FIELD_W-1:0] hour;
      logic [FIELD_W-1:0] min;
      logic [FIELD_W-1:0] sec;
   } cal_t;
endpackage

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp
   import rtc_alarm_pkg::*;
(
   input  cal_t              now,
   input  logic              now_half,
   input  cal_t              want,
   input  logic [CODE_W-1:0] code,
   output logic              hit
);
   logic use_half, use_s1, use_s, use_m1, use_m, use_h, use_wd, use_d, use_mo;
   logic known;

   always_comb begin
      known    = (code <= CODE_LAST);
      use_half = (code >= 4'd1);
      use_s1   = (code >= 4'd2);
      use_s    = (code >= 4'd3);
      use_m1   = (code >= 4'd4);
      use_m    = (code >= 4'd5);
      use_h    = (code >= 4'd6);
      use_wd   = (code == 4'd7);
      use_d    = (code >= 4'd8);
      use_mo   = (code == 4'd9);
      hit = known
         & (!use_half | !now_half)
         & (!use_s1   | (now.sec[3:0] == want.sec[3:0]))
         & (!use_s    | (now.sec      == want.sec))
         & (!use_m1   | (now.min[3:0] == want.min[3:0]))
         & (!use_m    | (now.min      == want.min))
         & (!use_h    | (now.hour     == want.hour))
         & (!use_wd   | (now.wday     == want.wday))
         & (!use_d    | (now.day      == want.day))
         & (!use_mo   | (now.month    == want.month));
   end
endmodule

// File: rtl/rtc_alarm_repeat.sv
module rtc_alarm_repeat #(
   parameter int RPT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [RPT_W-1:0] load_val,
   input  logic             fire,
   input  logic             chime,
   output logic [RPT_W-1:0] count,
   output logic             auto_off
);
   logic at_zero;

   assign at_zero  = (count == '0);
   assign auto_off = fire & at_zero & ~chime;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count <= '0;
      end else if (load) begin
         count <= load_val;
      end else if (fire) begin
         if (!at_zero)   count <= count - 1'b1;
         else if (chime) count <= '1;
      end
   end
endmodule

// File: rtl/rtc_alarm_regs.sv
module rtc_alarm_regs
   import rtc_alarm_pkg::*;
#(
   parameter int RPT_W = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_wr,
   input  logic               bus_rd,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [FIELD_W-1:0] bus_wdata,
   input  logic [RPT_W-1:0]   rpt_count,
   input  logic               auto_off,
   output logic [FIELD_W-1:0] bus_rdata,
   output logic               ctl_en,
   output logic               ctl_chime,
   output logic [CODE_W-1:0]  ctl_code,
   output logic [PTR_W-1:0]   win_ptr,
   output cal_t               want
);
   logic wr_ctrl, wr_lo, wr_hi, touch_hi;

   assign wr_ctrl  = bus_wr && (bus_addr == ADDR_CTRL);
   assign wr_lo    = bus_wr && (bus_addr == ADDR_WLO);
   assign wr_hi    = bus_wr && (bus_addr == ADDR_WHI);
   assign touch_hi = (bus_wr || bus_rd) && (bus_addr == ADDR_WHI);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_en    <= 1'b0;
         ctl_chime <= 1'b0;
         ctl_code  <= '0;
         win_ptr   <= '0;
         want      <= '0;
      end else begin
         if (wr_ctrl) begin
            ctl_en    <= bus_wdata[7];
            ctl_chime <= bus_wdata[6];
            ctl_code  <= bus_wdata[5:2];
            win_ptr   <= bus_wdata[1:0];
         end else begin
            if (auto_off) ctl_en <= 1'b0;
            if (touch_hi && (win_ptr != '0)) win_ptr <= win_ptr - 1'b1;
         end
         if (wr_lo) begin
            case (win_ptr)
               2'd0:    want.sec  <= bus_wdata;
               2'd1:    want.hour <= bus_wdata;
               2'd2:    want.day  <= bus_wdata;
               default: ;
            endcase
         end
         if (wr_hi) begin
            case (win_ptr)
               2'd0:    want.min   <= bus_wdata;
               2'd1:    want.wday  <= bus_wdata;
               2'd2:    want.month <= bus_wdata;
               default: ;
            endcase
         end
      end
   end

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         ADDR_CTRL: bus_rdata = {ctl_en, ctl_chime, ctl_code, win_ptr};
         ADDR_RPT:  bus_rdata = FIELD_W'(rpt_count);
         ADDR_WLO: begin
            case (win_ptr)
               2'd0:    bus_rdata = want.sec;
               2'd1:    bus_rdata = want.hour;
               2'd2:    bus_rdata = want.day;
               default: bus_rdata = '0;
            endcase
         end
         default: begin
            case (win_ptr)
               2'd0:    bus_rdata = want.min;
               2'd1:    bus_rdata = want.wday;
               2'd2:    bus_rdata = want.month;
               default: bus_rdata = '0;
            endcase
         end
      endcase
   end
endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match
   import rtc_alarm_pkg::*;
#(
   parameter int RPT_W          = 8,
   parameter bit EVT_REGISTERED = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               half_tick,
   input  logic               tm_half,
   input  logic [FIELD_W-1:0] tm_sec,
   input  logic [FIELD_W-1:0] tm_min,
   input  logic [FIELD_W-1:0] tm_hour,
   input  logic [FIELD_W-1:0] tm_wday,
   input  logic [FIELD_W-1:0] tm_day,
   input  logic [FIELD_W-1:0] tm_month,
   input  logic               bus_wr,
   input  logic               bus_rd,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [FIELD_W-1:0] bus_wdata,
   output logic [FIELD_W-1:0] bus_rdata,
   output logic               alarm_evt
);
   if (RPT_W < 1 || RPT_W > FIELD_W) begin : g_bad_rpt
      $error("rtc_alarm_match: RPT_W must lie in 1..FIELD_W");
   end

   logic              tick_q, tick_rise, hit, fire, auto_off;
   logic              cfg_en, cfg_chime;
   logic [CODE_W-1:0] cfg_code;
   logic [PTR_W-1:0]  win_ptr;
   logic [RPT_W-1:0]  rpt_q;
   cal_t              now, want;

   assign now = '{month: tm_month, day: tm_day, wday: tm_wday,
                  hour: tm_hour, min: tm_min, sec: tm_sec};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tick_q <= 1'b0;
      else        tick_q <= half_tick;
   end

   assign tick_rise = half_tick & ~tick_q;
   assign fire      = tick_rise & cfg_en & hit;

   rtc_alarm_cmp u_cmp (
      .now(now), .now_half(tm_half), .want(want), .code(cfg_code), .hit(hit)
   );

   rtc_alarm_repeat #(.RPT_W(RPT_W)) u_rpt (
      .clk(clk), .rst_n(rst_n),
      .load(bus_wr && (bus_addr == ADDR_RPT)),
      .load_val(bus_wdata[RPT_W-1:0]),
      .fire(fire), .chime(cfg_chime),
      .count(rpt_q), .auto_off(auto_off)
   );

   rtc_alarm_regs #(.RPT_W(RPT_W)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .rpt_count(rpt_q), .auto_off(auto_off),
      .bus_rdata(bus_rdata), .ctl_en(cfg_en), .ctl_chime(cfg_chime),
      .ctl_code(cfg_code), .win_ptr(win_ptr), .want(want)
   );

   if (EVT_REGISTERED) begin : g_evt_reg
      logic evt_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) evt_q <= 1'b0;
         else        evt_q <= fire;
      end
      assign alarm_evt = evt_q;
   end else begin : g_evt_comb
      assign alarm_evt = fire;
   end
endmodule

// File: rtl/rtc_alarm_chk.sv
module rtc_alarm_chk
   import rtc_alarm_pkg::*;
#(
   parameter int RPT_W          = 8,
   parameter bit EVT_REGISTERED = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              half_tick,
   input logic              bus_wr,
   input logic              bus_rd,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              alarm_evt,
   input logic              cfg_en,
   input logic              cfg_chime,
   input logic [CODE_W-1:0] cfg_code,
   input logic [PTR_W-1:0]  win_ptr,
   input logic [RPT_W-1:0]  rpt_q
);
   logic hi_touch;
   assign hi_touch = (bus_wr || bus_rd) && (bus_addr == ADDR_WHI);

   p_ptr_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
      hi_touch && (win_ptr != '0) |=> win_ptr == $past(win_ptr) - 1'b1);

   p_ptr_floor_r9: assert property (@(posedge clk) disable iff (!rst_n)
      hi_touch && (win_ptr == '0) |=> win_ptr == '0);

   if (EVT_REGISTERED) begin : g_seq
      p_evt_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
         alarm_evt |-> $past(half_tick));

      p_evt_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
         alarm_evt |=> !alarm_evt);

      p_evt_enabled_r11: assert property (@(posedge clk) disable iff (!rst_n)
         alarm_evt |-> $past(cfg_en));

      p_no_reserved_r4: assert property (@(posedge clk) disable iff (!rst_n)
         alarm_evt |-> $past(cfg_code) <= CODE_LAST);

      p_count_down_r5: assert property (@(posedge clk) disable iff (!rst_n)
         alarm_evt && !$past(bus_wr) && ($past(rpt_q) != '0)
         |-> rpt_q == $past(rpt_q) - 1'b1);

      p_self_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
         alarm_evt && !$past(bus_wr) && ($past(rpt_q) == '0) && !$past(cfg_chime)
         |-> !cfg_en && rpt_q == '0);

      p_chime_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
         alarm_evt && !$past(bus_wr) && ($past(rpt_q) == '0) && $past(cfg_chime)
         |-> cfg_en && rpt_q == '1);
   end
endmodule

bind rtc_alarm_match rtc_alarm_chk #(.RPT_W(RPT_W), .EVT_REGISTERED(EVT_REGISTERED)) u_chk (
   .clk(clk), .rst_n(rst_n), .half_tick(half_tick),
   .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
   .alarm_evt(alarm_evt), .cfg_en(cfg_en), .cfg_chime(cfg_chime),
   .cfg_code(cfg_code), .win_ptr(win_ptr), .rpt_q(rpt_q)
);

// File: tb/rtc_alarm_match_tb.sv
module rtc_alarm_match_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       half_tick = 1'b0;
   logic       tm_half = 1'b0;
   logic [7:0] tm_sec = '0, tm_min = '0, tm_hour = '0, tm_wday = '0, tm_day = '0, tm_month = '0;
   logic       bus_wr = 1'b0, bus_rd = 1'b0;
   logic [1:0] bus_addr = '0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic       alarm_evt;

   int errors = 0;
   int checks = 0;
   bit done = 0;

   // model state: field index 0 sec, 1 min, 2 hour, 3 wday, 4 day, 5 month
   logic [7:0] mv [6];
   logic [7:0] tv [6];
   logic       m_en = 0, m_chime = 0;
   logic [3:0] m_code = 0;
   logic [1:0] m_ptr = 0;
   logic [7:0] m_rpt = 0;

   always #10 clk = ~clk;

   rtc_alarm_match dut_i (
      .clk(clk), .rst_n(rst_n), .half_tick(half_tick), .tm_half(tm_half),
      .tm_sec(tm_sec), .tm_min(tm_min), .tm_hour(tm_hour), .tm_wday(tm_wday),
      .tm_day(tm_day), .tm_month(tm_month), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .alarm_evt(alarm_evt)
   );

   task automatic check(string tag, string what, logic [7:0] act, logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: %s got %h expected %h", tag, what, act, exp);
      end
   endtask

   function automatic int lo_slot(logic [1:0] p);
      return (p == 0) ? 0 : (p == 1) ? 2 : (p == 2) ? 4 : -1;
   endfunction
   function automatic int hi_slot(logic [1:0] p);
      return (p == 0) ? 1 : (p == 1) ? 3 : (p == 2) ? 5 : -1;
   endfunction

   function automatic bit exp_match(logic [3:0] c, logic h);
      bit s1 = (tv[0][3:0] == mv[0][3:0]);
      bit s  = (tv[0] == mv[0]);
      bit m1 = (tv[1][3:0] == mv[1][3:0]);
      bit m  = (tv[1] == mv[1]);
      bit hr = (tv[2] == mv[2]);
      case (c)
         4'd0: return 1;
         4'd1: return !h;
         4'd2: return !h && s1;
         4'd3: return !h && s;
         4'd4: return !h && s && m1;
         4'd5: return !h && s && m;
         4'd6: return !h && s && m && hr;
         4'd7: return !h && s && m && hr && (tv[3] == mv[3]);
         4'd8: return !h && s && m && hr && (tv[4] == mv[4]);
         4'd9: return !h && s && m && hr && (tv[4] == mv[4]) && (tv[5] == mv[5]);
         default: return 0;
      endcase
   endfunction

   task automatic bus_write(logic [1:0] a, logic [7:0] d);
      int sl;
      @(negedge clk);
      bus_wr = 1; bus_addr = a; bus_wdata = d;
      @(posedge clk); #1;
      bus_wr = 0;
      case (a)
         2'd0: begin m_en = d[7]; m_chime = d[6]; m_code = d[5:2]; m_ptr = d[1:0]; end
         2'd1: m_rpt = d;
         2'd2: begin sl = lo_slot(m_ptr); if (sl >= 0) mv[sl] = d; end
         default: begin
            sl = hi_slot(m_ptr); if (sl >= 0) mv[sl] = d;
            if (m_ptr != 0) m_ptr--;
         end
      endcase
   endtask

   task automatic bus_read(string tag, logic [1:0] a);
      logic [7:0] e;
      int sl;
      case (a)
         2'd0: e = {m_en, m_chime, m_code, m_ptr};
         2'd1: e = m_rpt;
         2'd2: begin sl = lo_slot(m_ptr); e = (sl >= 0) ? mv[sl] : 8'h00; end
         default: begin sl = hi_slot(m_ptr); e = (sl >= 0) ? mv[sl] : 8'h00; end
      endcase
      @(negedge clk);
      bus_rd = 1; bus_addr = a;
      #2 check(tag, $sformatf("read addr %0d", a), bus_rdata, e);
      @(posedge clk); #1;
      bus_rd = 0;
      if (a == 2'd3 && m_ptr != 0) m_ptr--;
   endtask

   task automatic tick(string tag, logic h, int hold);
      bit f;
      f = m_en && exp_match(m_code, h);
      @(negedge clk);
      tm_sec = tv[0]; tm_min = tv[1]; tm_hour = tv[2];
      tm_wday = tv[3]; tm_day = tv[4]; tm_month = tv[5];
      tm_half = h; half_tick = 1;
      @(posedge clk); @(negedge clk);
      check(tag, "alarm_evt at tick edge", {7'b0, alarm_evt}, {7'b0, f});
      if (f) begin
         if (m_rpt != 0) m_rpt--;
         else if (m_chime) m_rpt = 8'hFF;
         else m_en = 0;
      end
      for (int k = 1; k < hold; k++) begin
         @(posedge clk); @(negedge clk);
         check("R2", "alarm_evt while tick held", {7'b0, alarm_evt}, 8'h00);
      end
      half_tick = 0;
      @(posedge clk); @(negedge clk);
      check("R2", "alarm_evt after pulse", {7'b0, alarm_evt}, 8'h00);
   endtask

   task automatic load_values();
      bus_write(2'd0, {m_en, m_chime, m_code, 2'd2});
      bus_write(2'd2, mv[4]); bus_write(2'd3, mv[5]);
      bus_write(2'd2, mv[2]); bus_write(2'd3, mv[3]);
      bus_write(2'd2, mv[0]); bus_write(2'd3, mv[1]);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: run did not finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      foreach (mv[i]) begin mv[i] = 0; tv[i] = 0; end
      repeat (3) @(posedge clk);
      #1 rst_n = 1;

      // R1 reset state
      @(negedge clk);
      check("R1", "alarm_evt after reset", {7'b0, alarm_evt}, 8'h00);
      bus_read("R1", 2'd0);
      bus_read("R1", 2'd1);

      // R8 and R9: load fields through the window, read them back
      mv[0] = 8'h30; mv[1] = 8'h45; mv[2] = 8'h12; mv[3] = 8'h03; mv[4] = 8'h29; mv[5] = 8'h02;
      load_values();
      bus_read("R9", 2'd0);                       // pointer walked down to 0
      bus_write(2'd0, 8'b00_0000_10);
      bus_read("R8", 2'd2); bus_read("R8", 2'd2); // low access keeps pointer at 2
      bus_read("R8", 2'd3); bus_read("R8", 2'd2); bus_read("R8", 2'd3);
      bus_read("R8", 2'd2); bus_read("R8", 2'd3);
      bus_read("R9", 2'd3);                       // at 0, stays 0
      bus_read("R9", 2'd0);

      // R10 unimplemented slot
      bus_write(2'd0, 8'b00_0000_11);
      bus_write(2'd2, 8'h5A);
      bus_read("R10", 2'd2);
      bus_read("R10", 2'd0);
      bus_write(2'd0, 8'b00_0000_11);
      bus_write(2'd3, 8'hA5);
      bus_read("R10", 2'd0);
      bus_read("R10", 2'd3); bus_read("R10", 2'd2); bus_read("R10", 2'd3);
      bus_read("R10", 2'd2); bus_read("R10", 2'd3); bus_read("R10", 2'd2);

      // R3 yearly alarm on 02/29: matching date fires, 03/01 does not
      foreach (tv[i]) tv[i] = mv[i];
      bus_write(2'd1, 8'd5);
      bus_write(2'd0, {1'b1, 1'b0, 4'd9, 2'd0});
      tick("R3", 1'b0, 1);
      tv[4] = 8'h01; tv[5] = 8'h03;
      tick("R3", 1'b0, 1);
      bus_read("R5", 2'd1);

      // R11 disabled: matching time, no event
      foreach (tv[i]) tv[i] = mv[i];
      bus_write(2'd0, {1'b0, 1'b0, 4'd0, 2'd0});
      tick("R11", 1'b0, 1);

      // R2 held tick gives one event
      bus_write(2'd0, {1'b1, 1'b0, 4'd0, 2'd0});
      tick("R2", 1'b1, 3);

      // R5 and R6: count 1 then auto disable
      bus_write(2'd1, 8'd1);
      tick("R5", 1'b0, 1); bus_read("R5", 2'd1);
      tick("R6", 1'b0, 1); bus_read("R6", 2'd0); bus_read("R6", 2'd1);
      tick("R6", 1'b0, 1);

      // R7 chime wrap
      bus_write(2'd1, 8'd0);
      bus_write(2'd0, {1'b1, 1'b1, 4'd1, 2'd0});
      tick("R7", 1'b0, 1); bus_read("R7", 2'd1); bus_read("R7", 2'd0);

      // R4 reserved codes
      for (int c = 10; c < 16; c++) begin
         bus_write(2'd0, {1'b1, 1'b0, 4'(c), 2'd0});
         tick("R4", 1'b0, 1);
      end

      // random mix
      for (int it = 0; it < 150; it++) begin
         m_en = ($urandom % 8) != 0;
         m_chime = $urandom % 2;
         m_code = (($urandom % 8) == 0) ? 4'(10 + $urandom % 6) : 4'($urandom % 10);
         foreach (mv[i]) mv[i] = 8'($urandom);
         load_values();
         bus_write(2'd0, {m_en, m_chime, m_code, 2'd0});
         bus_write(2'd1, 8'($urandom % 4));
         for (int t = 0; t < 6; t++) begin
            foreach (tv[i]) tv[i] = (($urandom % 4) == 0) ? 8'($urandom) : mv[i];
            if (($urandom % 3) == 0) tv[0][7:4] = 4'($urandom);
            tick("R3", (($urandom % 4) == 0), 1 + (($urandom % 3) == 0));
         end
         bus_read("R5", 2'd1);
         bus_read("R6", 2'd0);
         if ((it % 5) == 0) begin
            bus_write(2'd0, {m_en, m_chime, m_code, 2'd2});
            for (int k = 0; k < 3; k++) begin
               bus_read("R8", 2'd2);
               bus_read("R8", 2'd3);
            end
         end
      end

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule